// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a group of interrupt inputs and turns source events into delivery requests for a presentation controller. Each source entry holds a target server number, a priority, a trigger kind and a two-bit presented/queued pair. It also holds a flag for a delivery that must be retried and a flag for an interrupt that arrived while the source was masked. Sources raise trigger events. The presentation side sends end-of-interrupt commands and answers every delivery with an accept or a reject.

Message-kind sources coalesce extra triggers. A trigger that arrives while an earlier one is still in service sets the queued bit, and that queued bit becomes exactly one redelivery when the end-of-interrupt arrives. A rejected delivery is not dropped. The source is flagged, and a request bit for the source's server is raised. When the controller later asks for a resend, every flagged source is delivered again. A masked source keeps its interrupt until it is given a usable priority.

Deliveries leave one at a time through a valid/ready handshake. When several sources are waiting, they go out in ascending source index order.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, `dlv_valid` is 0 and `resend_req` is all zeros. Every source starts as message kind, with priority 0xFF (masked), server 0 and an idle pair (P=0, Q=0).
- R2: The pair is stored with P in bit 0 and Q in bit 1. A trigger to a message-kind source sets the pair to {old P, 1}. A delivery is raised only when the result is exactly P=1, Q=0. For message-kind sources, `trig_lvl` has no effect.
- R3: An end-of-interrupt to a message-kind source sets the pair to {0, old Q}. If P is then 1, the source is delivered again; otherwise nothing is delivered.
- R4: For a level-kind source, a trigger with `trig_lvl`=1 sets P and `trig_lvl`=0 clears P. A delivery is raised only when P goes from 0 to 1.
- R5: An end-of-interrupt to a level-kind source leaves the pair unchanged. If P is still 1, the source is delivered again.
- R6: A source whose priority is 0xFF is never presented. Its delivery is remembered as masked-pending instead. A later configuration write with a priority other than 0xFF delivers it once.
- R7: A reject response (`rsp_valid`=1, `rsp_rej`=1) sets the resend flag of `rsp_idx` and sets bit [server of that source] of `resend_req`. An accept response (`rsp_rej`=0) changes nothing.
- R8: A scan request clears `resend_req[scan_srv]`. It also redelivers every source whose resend flag is set, in ascending index order, and clears those flags, so an immediate second scan delivers nothing.
- R9: While `dlv_valid`=1 and `dlv_ready`=0, the outputs `dlv_valid`, `dlv_idx`, `dlv_prio` and `dlv_srv` hold steady. Waiting sources are presented one at a time, lowest index first.
- R10: Every delivery carries the source index together with the server and priority that were configured for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source being configured |
| cfg_srv | input | SRV_W | Target server for the source |
| cfg_prio | input | PRIO_W | Source priority (all ones = masked) |
| cfg_lvl | input | 1 | 1 = level kind, 0 = message kind |
| trig_valid | input | 1 | Trigger event strobe |
| trig_idx | input | IDX_W | Triggering source |
| trig_lvl | input | 1 | Line value for level-kind sources |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | IDX_W | Source being completed |
| rsp_valid | input | 1 | Delivery response strobe |
| rsp_rej | input | 1 | 1 = reject, 0 = accept |
| rsp_idx | input | IDX_W | Source the response refers to |
| scan_valid | input | 1 | Resend scan request |
| scan_srv | input | SRV_W | Server whose request bit is cleared |
| resend_req | output | NUM_SRV | Per-server resend request bits |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery taken by the controller |
| dlv_idx | output | IDX_W | Delivered source index |
| dlv_prio | output | PRIO_W | Delivered priority |
| dlv_srv | output | SRV_W | Delivered target server |

## Verification
The pair logic is exercised with repeated triggers on a message source before and between end-of-interrupts. This separates a correct coalescing of many triggers into one redelivery from schemes that drop the queued trigger or deliver once per trigger. A level source is driven with assert, re-assert and deassert around end-of-interrupts, so that retained-P redelivery can be told apart from shift behaviour. Rejects on three sources of one server, followed by two scans, show the ascending redelivery order and that the resend flags are cleared. A masked source that is later unmasked, and a stalled handshake with a lower-index source arriving during the stall, separate remembered interrupts from lost ones and show that the output holds steady.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    // Pair layout: bit 0 = presented (P), bit 1 = queued (Q)
    localparam logic [1:0] PQ_IDLE = 2'b00;
    localparam logic [1:0] PQ_PRES = 2'b01;

    // message trigger: old P shifts into Q, P is set
    function automatic logic [1:0] pq_msg_trig(input logic [1:0] pq);
        return {pq[0], 1'b1};
    endfunction

    // message completion: Q shifts into P, Q clears
    function automatic logic [1:0] pq_msg_eoi(input logic [1:0] pq);
        return {1'b0, pq[1]};
    endfunction

endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             gnt_any,
    output logic [IDX_W-1:0] gnt_idx
);
    // lowest set index wins
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_src_rsnd.sv
module irq_src_rsnd #(
    parameter int NUM_SRV = 4,
    parameter int SRV_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRV-1:0] set_vec,
    input  logic               clr_valid,
    input  logic [SRV_W-1:0]   clr_srv,
    output logic [NUM_SRV-1:0] req
);
    logic [NUM_SRV-1:0] req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (clr_valid) req_d[clr_srv] = 1'b0;
        req_d = req_d | set_vec;  // a new reject wins over a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req = req_q;
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_SRV = 4,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int SRV_W  = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_srv,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               cfg_lvl,
    input  logic               trig_valid,
    input  logic [IDX_W-1:0]   trig_idx,
    input  logic               trig_lvl,
    input  logic               eoi_valid,
    input  logic [IDX_W-1:0]   eoi_idx,
    input  logic               rsp_valid,
    input  logic               rsp_rej,
    input  logic [IDX_W-1:0]   rsp_idx,
    input  logic               scan_valid,
    input  logic [SRV_W-1:0]   scan_srv,
    output logic [NUM_SRV-1:0] resend_req,
    output logic               dlv_valid,
    input  logic               dlv_ready,
    output logic [IDX_W-1:0]   dlv_idx,
    output logic [PRIO_W-1:0]  dlv_prio,
    output logic [SRV_W-1:0]   dlv_srv
);
    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    typedef struct packed {
        logic [SRV_W-1:0]  srv;
        logic [PRIO_W-1:0] prio;
        logic              lvl;
        logic [1:0]        pq;
        logic              rsnd;   // retry needed after reject
        logic              mpend;  // arrived while masked
        logic              dq;     // waiting for the output stage
    } ent_t;

    typedef struct packed {
        ent_t [NUM_SRC-1:0] ent;
        logic               busy;
        logic [IDX_W-1:0]   oidx;
        logic [PRIO_W-1:0]  oprio;
        logic [SRV_W-1:0]   osrv;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC-1:0] elig;
    logic               gnt_any;
    logic [IDX_W-1:0]   gnt_idx;
    logic [NUM_SRV-1:0] rsnd_set;
    logic [1:0]         pq_tmp;

    // only waiting, unmasked sources compete for the output stage
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = st_q.ent[i].dq && (st_q.ent[i].prio != PRIO_OFF);
        end
    end

    irq_src_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .req     (elig),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        st_d     = st_q;
        rsnd_set = '0;
        pq_tmp   = PQ_IDLE;

        // load the output stage first, so a same-cycle event re-arms dq
        if (!st_q.busy && gnt_any) begin
            st_d.busy               = 1'b1;
            st_d.oidx               = gnt_idx;
            st_d.oprio              = st_q.ent[gnt_idx].prio;
            st_d.osrv               = st_q.ent[gnt_idx].srv;
            st_d.ent[gnt_idx].dq    = 1'b0;
            st_d.ent[gnt_idx].rsnd  = 1'b0;
        end

        // configuration write; unmasking releases a kept interrupt
        if (cfg_we) begin
            st_d.ent[cfg_idx].srv  = cfg_srv;
            st_d.ent[cfg_idx].prio = cfg_prio;
            st_d.ent[cfg_idx].lvl  = cfg_lvl;
            if (cfg_prio != PRIO_OFF && st_d.ent[cfg_idx].mpend) begin
                st_d.ent[cfg_idx].mpend = 1'b0;
                st_d.ent[cfg_idx].dq    = 1'b1;
            end
        end

        // source trigger
        if (trig_valid) begin
            if (st_d.ent[trig_idx].lvl) begin
                if (trig_lvl && !st_d.ent[trig_idx].pq[0]) begin
                    st_d.ent[trig_idx].dq = 1'b1;
                end
                st_d.ent[trig_idx].pq[0] = trig_lvl;
            end else begin
                pq_tmp = pq_msg_trig(st_d.ent[trig_idx].pq);
                st_d.ent[trig_idx].pq = pq_tmp;
                if (pq_tmp == PQ_PRES) st_d.ent[trig_idx].dq = 1'b1;
            end
        end

        // end of interrupt
        if (eoi_valid) begin
            if (st_d.ent[eoi_idx].lvl) begin
                if (st_d.ent[eoi_idx].pq[0]) st_d.ent[eoi_idx].dq = 1'b1;
            end else begin
                pq_tmp = pq_msg_eoi(st_d.ent[eoi_idx].pq);
                st_d.ent[eoi_idx].pq = pq_tmp;
                if (pq_tmp[0]) st_d.ent[eoi_idx].dq = 1'b1;
            end
        end

        // reject from the presentation side
        if (rsp_valid && rsp_rej) begin
            st_d.ent[rsp_idx].rsnd       = 1'b1;
            rsnd_set[st_d.ent[rsp_idx].srv] = 1'b1;
        end

        // resend scan: flag cleared before the new attempt
        if (scan_valid) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (st_d.ent[i].rsnd && !(rsp_valid && rsp_rej && rsp_idx == IDX_W'(i))) begin
                    st_d.ent[i].rsnd = 1'b0;
                    st_d.ent[i].dq   = 1'b1;
                end
            end
        end

        // handshake completion
        if (st_q.busy && dlv_ready) st_d.busy = 1'b0;

        // masked sources keep their interrupt instead of presenting it
        for (int i = 0; i < NUM_SRC; i++) begin
            if (st_d.ent[i].dq && st_d.ent[i].prio == PRIO_OFF) begin
                st_d.ent[i].dq    = 1'b0;
                st_d.ent[i].mpend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                st_q.ent[i].prio <= PRIO_OFF;
            end
        end else begin
            st_q <= st_d;
        end
    end

    irq_src_rsnd #(.NUM_SRV(NUM_SRV), .SRV_W(SRV_W)) u_rsnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (rsnd_set),
        .clr_valid (scan_valid),
        .clr_srv   (scan_srv),
        .req       (resend_req)
    );

    assign dlv_valid = st_q.busy;
    assign dlv_idx   = st_q.oidx;
    assign dlv_prio  = st_q.oprio;
    assign dlv_srv   = st_q.osrv;

endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
    parameter int NUM_SRV = 4,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = 4,
    parameter int SRV_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rsp_valid,
    input logic               rsp_rej,
    input logic               scan_valid,
    input logic [SRV_W-1:0]   scan_srv,
    input logic [NUM_SRV-1:0] resend_req,
    input logic               dlv_valid,
    input logic               dlv_ready,
    input logic [IDX_W-1:0]   dlv_idx,
    input logic [PRIO_W-1:0]  dlv_prio,
    input logic [SRV_W-1:0]   dlv_srv
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_idx)
                                   && $stable(dlv_prio) && $stable(dlv_srv));

    assert_no_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio != {PRIO_W{1'b1}});

    assert_rej_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_rej && !scan_valid |=> resend_req != '0);

    assert_scan_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid && !(rsp_valid && rsp_rej) |=> !resend_req[$past(scan_srv)]);
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
    .NUM_SRV(NUM_SRV), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SRV_W(SRV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_rej(rsp_rej),
    .scan_valid(scan_valid), .scan_srv(scan_srv), .resend_req(resend_req),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_idx(dlv_idx),
    .dlv_prio(dlv_prio), .dlv_srv(dlv_srv)
);

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
    localparam int NUM_SRC = 16;
    localparam int NUM_SRV = 4;
    localparam int PRIO_W  = 8;
    localparam int IDX_W   = 4;
    localparam int SRV_W   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_lvl = 0;
    logic [IDX_W-1:0] cfg_idx = '0, trig_idx = '0, eoi_idx = '0, rsp_idx = '0;
    logic [SRV_W-1:0] cfg_srv = '0, scan_srv = '0;
    logic [PRIO_W-1:0] cfg_prio = '0;
    logic trig_valid = 0, trig_lvl = 0, eoi_valid = 0;
    logic rsp_valid = 0, rsp_rej = 0, scan_valid = 0, dlv_ready = 1;
    logic [NUM_SRV-1:0] resend_req;
    logic dlv_valid;
    logic [IDX_W-1:0] dlv_idx;
    logic [PRIO_W-1:0] dlv_prio;
    logic [SRV_W-1:0] dlv_srv;

    always #4 clk = ~clk;  // 125 MHz

    irq_src_ctrl #(.NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .PRIO_W(PRIO_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_srv(cfg_srv), .cfg_prio(cfg_prio), .cfg_lvl(cfg_lvl),
        .trig_valid(trig_valid), .trig_idx(trig_idx), .trig_lvl(trig_lvl),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx), .rsp_valid(rsp_valid),
        .rsp_rej(rsp_rej), .rsp_idx(rsp_idx), .scan_valid(scan_valid),
        .scan_srv(scan_srv), .resend_req(resend_req), .dlv_valid(dlv_valid),
        .dlv_ready(dlv_ready), .dlv_idx(dlv_idx), .dlv_prio(dlv_prio),
        .dlv_srv(dlv_srv)
    );

    int checks = 0;
    int errors = 0;
    int n_log = 0;
    int lg_idx [64];
    int lg_prio[64];
    int lg_srv [64];
    int cyc_cnt = 0;

    // transfer log, sampled just after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && dlv_valid && dlv_ready && n_log < 64) begin
            lg_idx[n_log]  = int'(dlv_idx);
            lg_prio[n_log] = int'(dlv_prio);
            lg_srv[n_log]  = int'(dlv_srv);
            n_log++;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cfg(input int idx, input int srv, input int prio, input bit lvl);
        cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_srv = SRV_W'(srv);
        cfg_prio = PRIO_W'(prio); cfg_lvl = lvl;
        cyc(1);
        cfg_we = 0;
    endtask

    task automatic do_trig(input int idx, input bit lvl);
        trig_valid = 1; trig_idx = IDX_W'(idx); trig_lvl = lvl;
        cyc(1);
        trig_valid = 0;
    endtask

    task automatic do_eoi(input int idx);
        eoi_valid = 1; eoi_idx = IDX_W'(idx);
        cyc(1);
        eoi_valid = 0;
    endtask

    task automatic do_rsp(input int idx, input bit rej);
        rsp_valid = 1; rsp_idx = IDX_W'(idx); rsp_rej = rej;
        cyc(1);
        rsp_valid = 0;
    endtask

    task automatic do_scan(input int srv);
        scan_valid = 1; scan_srv = SRV_W'(srv);
        cyc(1);
        scan_valid = 0;
    endtask

    task automatic t_reset;
        chk(dlv_valid == 0, "R1 dlv_valid after reset", int'(dlv_valid), 0);
        chk(resend_req == 0, "R1 resend_req after reset", int'(resend_req), 0);
    endtask

    task automatic t_masked;
        n_log = 0;
        do_trig(3, 1'b0);   // default priority is masked
        cyc(6);
        chk(n_log == 0, "R1 R6 masked source not presented", n_log, 0);
        do_cfg(3, 3, 5, 1'b0);
        cyc(6);
        chk(n_log == 1, "R6 unmask delivers kept interrupt", n_log, 1);
        chk(lg_idx[0] == 3 && lg_prio[0] == 5, "R6 R10 unmasked idx/prio", lg_prio[0], 5);
        chk(lg_srv[0] == 3, "R10 unmasked server", lg_srv[0], 3);
        do_eoi(3);
        cyc(4);
    endtask

    task automatic t_msg;
        do_cfg(2, 1, 'h10, 1'b0);
        n_log = 0;
        do_trig(2, 1'b0);   // trig_lvl ignored on message source
        cyc(6);
        chk(n_log == 1, "R2 first trigger delivers", n_log, 1);
        chk(lg_idx[0] == 2 && lg_prio[0] == 'h10 && lg_srv[0] == 1, "R10 message fields", lg_prio[0], 'h10);
        do_trig(2, 1'b1);
        do_trig(2, 1'b0);
        cyc(6);
        chk(n_log == 1, "R2 triggers in service coalesce", n_log, 1);
        do_eoi(2);
        cyc(6);
        chk(n_log == 2, "R3 eoi with queued redelivers once", n_log, 2);
        do_eoi(2);
        cyc(6);
        chk(n_log == 2, "R3 eoi with nothing queued is quiet", n_log, 2);
        do_eoi(2);
        cyc(6);
        chk(n_log == 2, "R3 extra eoi is quiet", n_log, 2);
    endtask

    task automatic t_level;
        do_cfg(5, 0, 'h20, 1'b1);
        n_log = 0;
        do_trig(5, 1'b1);
        cyc(6);
        chk(n_log == 1 && lg_idx[0] == 5, "R4 level assert delivers", n_log, 1);
        do_trig(5, 1'b1);
        cyc(6);
        chk(n_log == 1, "R4 re-assert while P set is quiet", n_log, 1);
        do_eoi(5);
        cyc(6);
        chk(n_log == 2, "R5 eoi with line high redelivers", n_log, 2);
        do_trig(5, 1'b0);
        do_eoi(5);
        cyc(6);
        chk(n_log == 2, "R4 R5 eoi after deassert is quiet", n_log, 2);
    endtask

    task automatic t_reject;
        do_cfg(9, 2, 3, 1'b0);
        do_cfg(7, 2, 3, 1'b0);
        do_cfg(4, 2, 3, 1'b0);
        n_log = 0;
        do_trig(9, 1'b0);
        do_trig(7, 1'b0);
        do_trig(4, 1'b0);
        cyc(10);
        chk(n_log == 3, "R9 three first deliveries", n_log, 3);
        chk(resend_req == 0, "R7 no request before reject", int'(resend_req), 0);
        do_rsp(9, 1'b1);
        cyc(1);
        chk(resend_req == 4'b0100, "R7 reject raises server bit", int'(resend_req), 4);
        do_rsp(4, 1'b1);
        do_rsp(7, 1'b1);
        cyc(4);
        chk(n_log == 3, "R7 reject alone delivers nothing", n_log, 3);
        n_log = 0;
        do_scan(2);
        cyc(12);
        chk(resend_req == 0, "R8 scan clears request bit", int'(resend_req), 0);
        chk(n_log == 3, "R8 scan redelivers flagged", n_log, 3);
        chk(lg_idx[0] == 4 && lg_idx[1] == 7 && lg_idx[2] == 9, "R8 ascending order",
            lg_idx[0] * 100 + lg_idx[1] * 10 + lg_idx[2], 4 * 100 + 7 * 10 + 9);
        n_log = 0;
        do_scan(2);
        cyc(8);
        chk(n_log == 0, "R8 flags cleared by scan", n_log, 0);
    endtask

    task automatic t_accept;
        n_log = 0;
        do_rsp(2, 1'b0);
        cyc(2);
        chk(resend_req == 0, "R7 accept raises nothing", int'(resend_req), 0);
        do_scan(1);
        cyc(6);
        chk(n_log == 0, "R7 accept leaves no flag", n_log, 0);
    endtask

    task automatic t_stall;
        do_cfg(1, 3, 8, 1'b0);
        n_log = 0;
        dlv_ready = 0;
        do_trig(2, 1'b0);
        cyc(3);
        chk(dlv_valid == 1 && dlv_idx == 2, "R9 valid presented idx 2", int'(dlv_idx), 2);
        do_trig(1, 1'b0);
        cyc(4);
        chk(dlv_valid == 1 && dlv_idx == 2 && dlv_prio == 'h10, "R9 held during stall",
            int'(dlv_idx), 2);
        dlv_ready = 1;
        cyc(8);
        chk(n_log == 2, "R9 both delivered", n_log, 2);
        chk(lg_idx[0] == 2 && lg_idx[1] == 1 && lg_prio[1] == 8 && lg_srv[1] == 3,
            "R9 R10 order and fields", lg_idx[1], 1);
    endtask

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1);
        t_reset;
        t_masked;
        t_msg;
        t_level;
        t_reject;
        t_accept;
        t_stall;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule